// File: doc/BRIEF.md
# Cache Range Maintenance Line Walker

This block carries out one maintenance operation (clean, invalidate, or clean followed by invalidate) over a range of cache lines. Software first writes a start address, then an end address together with an operation code. The end write launches the walk. The walker then emits one per-line command for every line whose first byte lies between start and end, both inclusive. Each command uses a valid/ready handshake toward the cache's tag and write-back logic, which sit outside this block.

While the walk runs, `busy` stalls the requester. When the last line command is accepted, `done` pulses for one cycle and `busy` falls in that same cycle. Only the start address would be translated, so start and end must lie in the same 4 KiB page. A request that crosses pages is rejected with an error pulse and issues nothing. A range that holds no line base finishes at once with no commands.

Top module: `range_walker`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `cmd_valid` are all 0.
- R2: A write with `wr_sel`=0 captures the start address. A later write with `wr_sel`=1 and a nonzero `wr_op` launches the walk. The first command appears in the cycle after that write, at the lowest 32-byte-aligned address that is not below start.
- R3: Commands step by 32 bytes through every aligned line base from the first line up to and including the end address rounded down to 32 bytes. Each such line is issued exactly once.
- R4: `cmd_op` carries the launching `wr_op` code on every command: 1 = clean, 2 = invalidate, 3 = clean and invalidate. An end write with `wr_op`=0 is ignored and launches nothing.
- R5: Once `cmd_valid` is high, it stays high with `cmd_addr` and `cmd_op` unchanged until `cmd_ready` is seen high. The walk advances only on acceptance.
- R6: `busy` is high from the cycle after launch until the cycle after the final command is accepted. In that cycle `done` is high for exactly one cycle while `busy` is low.
- R7: If start and end differ in address bits 31:12, `err` pulses for one cycle in the cycle after the end write. No command is issued and `busy` stays low.
- R8: If no aligned line base lies in the inclusive range, `done` pulses in the cycle after the end write. This covers an end below start. No command is issued and `busy` stays low.
- R9: Writes to either register while `busy` is high are ignored. They change neither the running walk nor the start address used by the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = start register, 1 = end register (launch) |
| wr_op | input | 2 | Operation code sent with the end write |
| wr_addr | input | ADDR_W | Address being written |
| busy | output | 1 | Requester stall, high during a walk |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle page-crossing rejection pulse |
| cmd_valid | output | 1 | Line command valid |
| cmd_ready | input | 1 | Line command accepted |
| cmd_addr | output | ADDR_W | Line base address of the command |
| cmd_op | output | 2 | Operation code of the command |

## Verification
All outputs are registered, so every result of an end write is due one cycle after the write edge:
- the first command with `busy` for a real range;
- `done` for an empty range;
- `err` for a page crossing.

`done` and the fall of `busy` come one cycle after the edge where the last command is accepted. The bench drives inputs just after the rising edge and samples on the falling edge. It logs each accepted command at the falling edge before its acceptance edge and checks the launch outcome at the first falling edge after the write. It then waits for the `done` falling edge and confirms the pulse has cleared one cycle later. Ready is throttled in several patterns so that the hold-until-accepted rule and the per-line stepping are exercised under backpressure.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_CLEAN = 2'd1,
    OP_INVAL = 2'd2,
    OP_FLUSH = 2'd3
  } rmw_op_e;
endpackage

// File: rtl/rmw_launch.sv
module rmw_launch
  import rmw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [1:0]        wr_op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              busy,
  output logic              go,
  output logic [ADDR_W-1:0] go_first,
  output logic [ADDR_W-1:0] go_last,
  output rmw_op_e           go_op,
  output logic              go_bad,
  output logic              go_empty
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W:0]   round_up;

  // start register: only writable while no walk is running
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
    end else if (wr_en && !wr_sel && !busy) begin
      start_q <= wr_addr;
    end
  end

  always_comb begin
    round_up = {1'b0, start_q} + (ADDR_W+1)'(LINE_BYTES - 1);
    go_first = round_up[ADDR_W-1:0] & ~LINE_MASK;
    go_last  = wr_addr & ~LINE_MASK;
    go_op    = rmw_op_e'(wr_op);
    go_bad   = start_q[ADDR_W-1:PG_W] != wr_addr[ADDR_W-1:PG_W];
    go_empty = round_up[ADDR_W] || (go_first > go_last);
    go       = wr_en && wr_sel && !busy && (go_op != OP_NONE);
  end
endmodule

// File: rtl/rmw_walk.sv
module rmw_walk
  import rmw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_first,
  input  logic [ADDR_W-1:0] go_last,
  input  rmw_op_e           go_op,
  input  logic              go_bad,
  input  logic              go_empty,
  input  logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output rmw_op_e           cmd_op
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LINE_BYTES);

  logic              run_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] last_q;
  rmw_op_e           op_q;
  logic              done_q;
  logic              err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      addr_q <= '0;
      last_q <= '0;
      op_q   <= OP_NONE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (run_q) begin
        if (cmd_ready) begin
          if (addr_q == last_q) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            addr_q <= addr_q + STEP;
          end
        end
      end else if (go) begin
        if (go_bad) begin
          err_q <= 1'b1;
        end else if (go_empty) begin
          done_q <= 1'b1;
        end else begin
          run_q  <= 1'b1;
          addr_q <= go_first;
          last_q <= go_last;
          op_q   <= go_op;
        end
      end
    end
  end

  assign busy      = run_q;
  assign cmd_valid = run_q;
  assign cmd_addr  = addr_q;
  assign cmd_op    = op_q;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/range_walker.sv
module range_walker
  import rmw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [1:0]        wr_op,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [1:0]        cmd_op
);
  logic              go, go_bad, go_empty;
  logic [ADDR_W-1:0] go_first, go_last;
  rmw_op_e           go_op;
  rmw_op_e           op_out;

  rmw_launch #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_launch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_op(wr_op),
    .wr_addr(wr_addr), .busy(busy), .go(go), .go_first(go_first),
    .go_last(go_last), .go_op(go_op), .go_bad(go_bad), .go_empty(go_empty)
  );

  rmw_walk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_walk (
    .clk(clk), .rst(rst), .go(go), .go_first(go_first), .go_last(go_last),
    .go_op(go_op), .go_bad(go_bad), .go_empty(go_empty), .cmd_ready(cmd_ready),
    .busy(busy), .done(done), .err(err), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_op(op_out)
  );

  assign cmd_op = op_out;
endmodule

// File: rtl/rmw_checker.sv
module rmw_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [1:0]        cmd_op
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_op));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_valid || (cmd_addr == $past(cmd_addr) + ADDR_W'(LINE_BYTES)));

  p_align_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_addr[OFF_W-1:0] == '0);

  p_op_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_op != 2'd0);

  p_fall_done_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy && !done && !cmd_valid);

  p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    busy && !(cmd_valid && cmd_ready) |=> busy && !err && !done);
endmodule

bind range_walker rmw_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_op(cmd_op)
);

// File: tb/range_walker_tb_top.sv
module range_walker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [1:0]  wr_op = 2'd0;
  logic [31:0] wr_addr = '0;
  logic        busy, done, err, cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [31:0] cmd_addr;
  logic [1:0]  cmd_op;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int rdy_mode = 0;
  int rcnt = 0;
  int log_n = 0;
  int done_cnt = 0;
  logic [31:0] log_addr [0:255];
  logic [1:0]  log_op [0:255];
  logic        pv = 1'b0, pr = 1'b0;
  logic [31:0] pa = '0;

  range_walker dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_op(wr_op),
    .wr_addr(wr_addr), .busy(busy), .done(done), .err(err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_op(cmd_op)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    #1;
    rcnt++;
    case (rdy_mode)
      0: cmd_ready = 1'b1;
      1: cmd_ready = rcnt[0];
      default: cmd_ready = (rcnt % 3) != 0;
    endcase
  end

  // command log and handshake hold check (R5)
  always @(negedge clk) begin
    if (!rst) begin
      if (pv && !pr)
        chk(cmd_valid && cmd_addr == pa, "R5", cmd_addr, pa);
      if (cmd_valid && cmd_ready && log_n < 256) begin
        log_addr[log_n] = cmd_addr;
        log_op[log_n]   = cmd_op;
        log_n++;
      end
      if (done) done_cnt++;
    end
    pv = cmd_valid; pr = cmd_ready; pa = cmd_addr;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wr(input bit sel, input logic [1:0] op, input logic [31:0] a);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_op = op; wr_addr = a;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // launch end write (start already written), check everything
  task automatic walk(input logic [31:0] s, input logic [31:0] e, input logic [1:0] op);
    logic [32:0] f33;
    logic [31:0] first, last;
    bit bad, empty;
    int exp_n, bad_lines;
    f33   = {1'b0, s} + 33'd31;
    first = f33[31:0] & ~32'd31;
    last  = e & ~32'd31;
    bad   = (s[31:12] != e[31:12]);
    empty = f33[32] || (first > last);
    exp_n = (bad || empty) ? 0 : int'((last - first) / 32) + 1;
    log_n = 0; done_cnt = 0;
    wr(1'b1, op, e);
    @(negedge clk);
    if (bad) begin
      chk(err && !busy && !cmd_valid, "R7", {busy, err}, 32'h1);
    end else if (empty) begin
      chk(done && !busy && !cmd_valid, "R8", {busy, done}, 32'h1);
    end else begin
      chk(busy && cmd_valid && cmd_addr == first, "R2", cmd_addr, first);
      for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
      chk(done && !busy, "R6", {busy, done}, 32'h1);
    end
    @(negedge clk); #1;
    chk(!done && !err && !busy, "R6", {busy, done, err}, 32'h0);
    chk(log_n == exp_n, "R3", log_n, exp_n);
    chk(done_cnt == (bad ? 0 : 1), "R6", done_cnt, bad ? 0 : 1);
    bad_lines = 0;
    for (int i = 0; i < log_n; i++)
      if (log_addr[i] != first + 32'(i * 32) || log_op[i] != op) bad_lines++;
    chk(bad_lines == 0, "R3 R4", bad_lines, 0);
  endtask

  task automatic t_range(input logic [31:0] s, input logic [31:0] e, input logic [1:0] op, input int mode);
    rdy_mode = mode;
    wr(1'b0, 2'd0, s);
    walk(s, e, op);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && !err && !cmd_valid, "R1", {busy, done, err, cmd_valid}, 32'h0);
  endtask

  task automatic t_op_none();
    log_n = 0; done_cnt = 0;
    wr(1'b0, 2'd0, 32'h0000_0200);
    wr(1'b1, 2'd0, 32'h0000_021F);
    repeat (4) @(negedge clk);
    chk(!busy && log_n == 0 && done_cnt == 0, "R4", log_n, 0);
  endtask

  task automatic t_busy_writes();
    rdy_mode = 1;
    log_n = 0; done_cnt = 0;
    wr(1'b0, 2'd0, 32'h0000_8100);
    wr(1'b1, 2'd2, 32'h0000_817F);
    wr(1'b0, 2'd0, 32'h0000_8800);
    wr(1'b1, 2'd1, 32'h0000_89FF);
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(log_n == 4 && log_addr[3] == 32'h8160, "R9", log_n, 4);
    // start must still be 0x8100: end-only relaunch covers two lines
    walk(32'h0000_8100, 32'h0000_813F, 2'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_range(32'h0000_1000, 32'h0000_10FF, 2'd1, 0);
    t_range(32'h0000_2005, 32'h0000_2043, 2'd2, 1);
    t_range(32'h0000_3000, 32'h0000_3FFF, 2'd3, 2);
    t_range(32'h0000_4040, 32'h0000_4040, 2'd1, 1);
    t_range(32'h0000_5FE0, 32'h0000_6010, 2'd3, 0);
    t_range(32'h0000_7100, 32'h0000_7000, 2'd2, 0);
    t_range(32'h0000_7101, 32'h0000_711F, 2'd1, 0);
    t_op_none();
    t_busy_writes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule